// File: doc/BRIEF.md
# OFDM Symbol Deinterleaver Address Generator

This block produces the address stream that undoes the block frequency interleaving applied to the data carriers of one OFDM symbol. A block holds 1512 words in the short (2k) mode and 6048 words in the long (8k) mode. The permuted index H(q) comes from a maximal-length shift register whose bits are rewired and topped with an alternating most significant bit. Candidates that fall outside the block are dropped internally, so only legal addresses reach the consumer.

Two word memories alternate every symbol: one is written with the incoming symbol while the other is read for the previous one. On an even symbol the writer stores word q at address q, and the reader of the previous odd symbol fetches at q. On an odd symbol the writer stores word q at H(q), and the reader of the previous even symbol fetches at H(q). Writer and reader therefore always share one address, and no memory-to-memory reorder pass is needed. A single address output serves both memories, with a bank flag naming the memory being written; the other one is read.

Top module: `ofdm_symdeint_agen`

## Requirements
- R1: While reset is asserted and afterwards until the first symbol start, `addr_vld` is 0, `sym_num` is 67 and `wr_bank` is 1.
- R2: `mode_sel` is sampled on `sym_start`. Only code 2'b01 selects the long mode, with a block of 6048 words. Codes 2'b00, 2'b10 and 2'b11 select the short mode, with a block of 1512 words.
- R3: In the cycle after `sym_start`, `addr_vld` is 1 and `addr` is 0. `sym_num` moves to the next value modulo 68, and `wr_bank` equals bit 0 of `sym_num` (0 for an even symbol).
- R4: On an even symbol the valid addresses are 0, 1, 2, ... Nmax-1 in that order.
- R5: On an odd symbol the valid addresses follow H(q), where q counts valid addresses and i counts generator steps from 0. The register is 10 bits (short) or 12 bits (long). It is 0 for i=0 and i=1 and 1 for i=2. After that it shifts right, and its top bit takes the XOR of bits 0 and 3 (short) or of bits 0, 1, 4 and 6 (long). Register bit k moves to candidate bit P[k]. For the short mode P = 4,3,9,6,2,8,1,5,7,0 for k=0..9. For the long mode P = 7,1,4,2,9,6,8,10,0,3,11,5 for k=0..11. Bit 10 (short) or bit 12 (long) of the candidate is i mod 2.
- R6: Each symbol yields exactly Nmax valid addresses, all below Nmax and none repeated. After that `addr_vld` stays 0 until the next `sym_start`.
- R7: A candidate of Nmax or more is dropped with `addr_vld` at 0, and the generator steps again on its own without `advance`.
- R8: While `addr_vld` is 1 and `advance` is 0, the address is held unchanged and stays valid.
- R9: `sym_num` wraps from 67 to 0, and `wr_bank` goes from 1 to 0 at that wrap.
- R10: A `sym_start` in the middle of a block abandons it and restarts at q=0 for the next symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Block-size code, sampled at symbol start |
| sym_start | input | 1 | One-cycle strobe that begins a new OFDM symbol |
| advance | input | 1 | Consumer takes the current valid address |
| addr | output | 13 | Shared write/read address for both memories |
| addr_vld | output | 1 | Address is legal and may be consumed |
| wr_bank | output | 1 | Memory being written (0 even, 1 odd); the other is read |
| sym_num | output | 7 | Symbol number within the frame, 0 to 67 |

## Verification
The assertions assume `sym_start` is a single-cycle strobe. They also assume `advance` only carries meaning while `addr_vld` is high, and they hold the consumer to taking at most one address per valid cycle. The block's own counter is not trusted: the checker counts consumed addresses against the latched block size. The stimulus changes inputs only on the falling clock edge and pulses `sym_start` for exactly one cycle. It changes `mode_sel` only at symbol starts, and drives `advance` both continuously and in a gapped pattern, so the hold and skip behaviour is exercised under both consumer rates.

// File: rtl/symdeint_pkg.sv
package symdeint_pkg;
  localparam int LFSR_W  = 12;
  localparam int SHORT_W = 10;
  localparam int ADDR_W  = LFSR_W + 1;
  localparam int N_SHORT = 1512;
  localparam int N_LONG  = 6048;
  localparam int SYMS    = 68;
  localparam int SYM_W   = $clog2(SYMS);
  localparam logic [1:0] MODE_LONG = 2'b01;

  // wire rewiring of the short-mode register into candidate bits
  function automatic logic [SHORT_W-1:0] rewire_short(input logic [SHORT_W-1:0] s);
    logic [SHORT_W-1:0] r;
    r[4] = s[0]; r[3] = s[1]; r[9] = s[2]; r[6] = s[3]; r[2] = s[4];
    r[8] = s[5]; r[1] = s[6]; r[5] = s[7]; r[7] = s[8]; r[0] = s[9];
    return r;
  endfunction

  // wire rewiring of the long-mode register into candidate bits
  function automatic logic [LFSR_W-1:0] rewire_long(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] r;
    r[7]  = s[0]; r[1] = s[1]; r[4]  = s[2]; r[2]  = s[3];
    r[9]  = s[4]; r[6] = s[5]; r[8]  = s[6]; r[10] = s[7];
    r[0]  = s[8]; r[3] = s[9]; r[11] = s[10]; r[5] = s[11];
    return r;
  endfunction
endpackage

// File: rtl/symdeint_prbs.sv
module symdeint_prbs
  import symdeint_pkg::*;
#(
  parameter int LW = LFSR_W,
  parameter int SW = SHORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          long_mode,
  output logic [AW-1:0] cand
);
  localparam logic [1:0] PH_ZERO0 = 2'd0;
  localparam logic [1:0] PH_ZERO1 = 2'd1;
  localparam logic [1:0] PH_RUN   = 2'd2;

  logic [LW-1:0] lfsr_q, lfsr_d;
  logic [1:0]    ph_q, ph_d;
  logic          tgl_q, tgl_d;
  logic          fb_short, fb_long;
  logic [LW-1:0] shifted;

  assign fb_short = lfsr_q[0] ^ lfsr_q[3];
  assign fb_long  = lfsr_q[0] ^ lfsr_q[1] ^ lfsr_q[4] ^ lfsr_q[6];
  assign shifted  = long_mode ? {fb_long, lfsr_q[LW-1:1]}
                              : {{(LW-SW){1'b0}}, fb_short, lfsr_q[SW-1:1]};

  always_comb begin
    lfsr_d = lfsr_q;
    ph_d   = ph_q;
    tgl_d  = tgl_q;
    if (clr) begin
      lfsr_d = '0;
      ph_d   = PH_ZERO0;
      tgl_d  = 1'b0;
    end else if (step) begin
      tgl_d = ~tgl_q;
      case (ph_q)
        PH_ZERO0: ph_d = PH_ZERO1;
        PH_ZERO1: begin
          ph_d   = PH_RUN;
          lfsr_d = LW'(1);
        end
        default:  lfsr_d = shifted;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
      ph_q   <= PH_ZERO0;
      tgl_q  <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      ph_q   <= ph_d;
      tgl_q  <= tgl_d;
    end
  end

  assign cand = long_mode ? AW'({tgl_q, rewire_long(lfsr_q)})
                          : AW'({tgl_q, rewire_short(lfsr_q[SW-1:0])});
endmodule

// File: rtl/symdeint_frame.sv
module symdeint_frame
  import symdeint_pkg::*;
#(
  parameter int NS = SYMS,
  parameter int NW = SYM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_start,
  output logic [NW-1:0] sym_num,
  output logic          odd
);
  localparam logic [NW-1:0] LAST = NW'(NS - 1);

  logic [NW-1:0] sym_q, sym_d;

  always_comb begin
    sym_d = sym_q;
    if (sym_start) sym_d = (sym_q == LAST) ? '0 : sym_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= LAST;
    else        sym_q <= sym_d;
  end

  assign sym_num = sym_q;
  assign odd     = sym_q[0];
endmodule

// File: rtl/ofdm_symdeint_agen.sv
module ofdm_symdeint_agen
  import symdeint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              sym_start,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld,
  output logic              wr_bank,
  output logic [SYM_W-1:0]  sym_num
);
  logic [1:0]        rs_q;
  logic              rst_ni;
  logic [ADDR_W-1:0] q_q, q_d, nmax, cand;
  logic              act_q, act_d, long_q, long_d;
  logic              cand_ok, take, step, odd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign nmax    = long_q ? ADDR_W'(N_LONG) : ADDR_W'(N_SHORT);
  assign cand_ok = act_q && (cand < nmax);
  assign take    = cand_ok && advance;
  assign step    = act_q && (!cand_ok || advance);

  always_comb begin
    q_d    = q_q;
    act_d  = act_q;
    long_d = long_q;
    if (sym_start) begin
      q_d    = '0;
      act_d  = 1'b1;
      long_d = (mode_sel == MODE_LONG);
    end else if (take) begin
      q_d = q_q + 1'b1;
      if (q_q == nmax - 1'b1) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      act_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      act_q  <= act_d;
      long_q <= long_d;
    end
  end

  symdeint_prbs u_prbs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (sym_start),
    .step      (step),
    .long_mode (long_q),
    .cand      (cand)
  );

  symdeint_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sym_start (sym_start),
    .sym_num   (sym_num),
    .odd       (odd)
  );

  assign wr_bank  = odd;
  assign addr_vld = cand_ok;
  assign addr     = odd ? cand : q_q;
endmodule

// File: rtl/symdeint_chk.sv
module symdeint_chk
  import symdeint_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sym_start,
  input logic              advance,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_vld,
  input logic              wr_bank,
  input logic [SYM_W-1:0]  sym_num,
  input logic              long_mode
);
  logic [ADDR_W-1:0] lim;
  logic [ADDR_W-1:0] taken_q;

  assign lim = long_mode ? ADDR_W'(N_LONG) : ADDR_W'(N_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         taken_q <= '0;
    else if (sym_start)                 taken_q <= '0;
    else if (addr_vld && advance)       taken_q <= taken_q + 1'b1;
  end

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> addr < lim);

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && advance && !sym_start) |-> taken_q < lim);

  // R3
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> addr_vld && addr == '0);

  // R3
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> wr_bank != $past(wr_bank));

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !advance && !sym_start) |=> addr_vld && $stable(addr));

  // R9
  sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_num < SYM_W'(SYMS));
endmodule

bind ofdm_symdeint_agen symdeint_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .sym_start (sym_start),
  .advance   (advance),
  .addr      (addr),
  .addr_vld  (addr_vld),
  .wr_bank   (wr_bank),
  .sym_num   (sym_num),
  .long_mode (long_q)
);

// File: tb/sim_ofdm_symdeint_agen.sv
module sim_ofdm_symdeint_agen;
  import symdeint_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, sym_start, advance;
  logic [1:0]        mode_sel;
  logic [ADDR_W-1:0] addr;
  logic              addr_vld, wr_bank;
  logic [SYM_W-1:0]  sym_num;

  ofdm_symdeint_agen u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sym_start(sym_start),
    .advance(advance), .addr(addr), .addr_vld(addr_vld), .wr_bank(wr_bank),
    .sym_num(sym_num)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int got [N_LONG];
  int got_s [N_SHORT];
  int got_l [N_LONG];
  bit seen [N_LONG];
  int m_reg, m_i;

  // mode (0 short, 1 long), q, expected H(q)
  localparam int VEC [10][3] = '{
    '{0,0,0}, '{0,1,1024}, '{0,2,16}, '{0,3,1025}, '{0,4,128},
    '{1,0,0}, '{1,1,4096}, '{1,2,128}, '{1,3,4128}, '{1,4,2048}};
  localparam int MAP_S [10] = '{4,3,9,6,2,8,1,5,7,0};
  localparam int MAP_L [12] = '{7,1,4,2,9,6,8,10,0,3,11,5};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mdl_next(input bit lng, output int h);
    int nb, lim, rp, fb;
    nb  = lng ? 12 : 10;
    lim = lng ? N_LONG : N_SHORT;
    forever begin
      if (m_i < 2) rp = 0;
      else if (m_i == 2) rp = 1;
      else begin
        if (lng) fb = (m_reg ^ (m_reg >> 1) ^ (m_reg >> 4) ^ (m_reg >> 6)) & 1;
        else     fb = (m_reg ^ (m_reg >> 3)) & 1;
        rp = (m_reg >> 1) | (fb << (nb - 1));
      end
      m_reg = rp;
      h = (m_i % 2) << nb;
      for (int k = 0; k < nb; k++)
        if (((rp >> k) & 1) == 1) h = h | (1 << (lng ? MAP_L[k] : MAP_S[k]));
      m_i++;
      if (h < lim) return;
    end
  endtask

  task automatic start_sym(input logic [1:0] ms);
    @(negedge clk);
    mode_sel  = ms;
    sym_start = 1'b1;
    advance   = 1'b0;
    @(negedge clk);
    sym_start = 1'b0;
  endtask

  task automatic run_block(input logic [1:0] ms, input bit gappy,
                           output int cnt, output int inval);
    int cyc, lim;
    cyc = 0; cnt = 0; inval = 0;
    lim = (ms == 2'b01) ? N_LONG : N_SHORT;
    start_sym(ms);
    while (cnt < lim && cyc < 20000) begin
      advance = gappy ? ((cyc % 3) != 0) : 1'b1;
      if (addr_vld && advance) begin
        got[cnt] = int'(addr);
        cnt++;
      end else if (!addr_vld) inval++;
      cyc++;
      @(negedge clk);
    end
    advance = 1'b0;
  endtask

  task automatic check_order(input string req, input int cnt);
    int bad;
    bad = 0;
    for (int k = 0; k < cnt; k++) if (got[k] != k) bad++;
    check(req, bad, 0);
  endtask

  task automatic check_odd(input bit lng, input int cnt);
    int bad, dup, h;
    bad = 0; dup = 0; m_reg = 0; m_i = 0;
    for (int k = 0; k < N_LONG; k++) seen[k] = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      mdl_next(lng, h);
      if (got[k] != h) bad++;
      if (got[k] < 0 || got[k] >= N_LONG) dup++;
      else if (seen[got[k]]) dup++;
      else seen[got[k]] = 1'b1;
    end
    check("R5 odd sequence vs H(q) model mismatches", bad, 0);
    check("R6 repeated or out-of-range addresses", dup, 0);
  endtask

  task automatic check_idle();
    advance = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 addr_vld after block end", int'(addr_vld), 0);
    advance = 1'b0;
  endtask

  initial begin
    int cnt, inv;
    rst_n = 1'b0; sym_start = 1'b0; advance = 1'b0; mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 addr_vld in reset", int'(addr_vld), 0);
    check("R1 sym_num in reset", int'(sym_num), 67);
    check("R1 wr_bank in reset", int'(wr_bank), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 addr_vld idle after reset", int'(addr_vld), 0);

    // even short symbol
    run_block(2'b00, 1'b0, cnt, inv);
    check("R6 short even count", cnt, N_SHORT);
    check_order("R4 short even order", cnt);
    check("R3 sym_num first symbol", int'(sym_num), 0);
    check("R3 wr_bank even", int'(wr_bank), 0);
    check_idle();

    // odd symbol, code 2'b10 must give short mode, gapped consumer
    run_block(2'b10, 1'b1, cnt, inv);
    check("R2 code 10 short count", cnt, N_SHORT);
    check("R3 wr_bank odd", int'(wr_bank), 1);
    check_odd(1'b0, cnt);
    check("R7 dropped candidates seen", int'(inv > 0), 1);
    for (int k = 0; k < N_SHORT; k++) got_s[k] = got[k];
    check_idle();

    // hold and mid-block restart
    start_sym(2'b00);
    check("R3 addr after start", int'(addr), 0);
    check("R3 sym_num 2", int'(sym_num), 2);
    repeat (4) @(negedge clk);
    check("R8 held addr", int'(addr), 0);
    check("R8 held valid", int'(addr_vld), 1);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R8 step after advance", int'(addr), 1);
    run_block(2'b01, 1'b0, cnt, inv);
    check("R10 restart sym_num", int'(sym_num), 3);
    check("R10 restart first address", got[0], 0);
    check("R2 long odd count", cnt, N_LONG);
    check_odd(1'b1, cnt);
    for (int k = 0; k < N_LONG; k++) got_l[k] = got[k];
    check_idle();

    // table walk of known H(q) values
    for (int r = 0; r < 10; r++)
      check("R5 table H(q)", (VEC[r][0] == 1) ? got_l[VEC[r][1]] : got_s[VEC[r][1]], VEC[r][2]);

    // even long symbol, gapped
    run_block(2'b01, 1'b1, cnt, inv);
    check("R2 long even count", cnt, N_LONG);
    check_order("R4 long even order", cnt);
    check("R3 sym_num 4", int'(sym_num), 4);

    // frame wrap
    for (int s = 0; s < 63; s++) start_sym(2'b00);
    check("R9 sym_num last", int'(sym_num), 67);
    check("R9 wr_bank last", int'(wr_bank), 1);
    start_sym(2'b00);
    check("R9 sym_num wrapped", int'(sym_num), 0);
    check("R9 wr_bank wrapped", int'(wr_bank), 0);
    check("R9 first valid after wrap", int'(addr_vld), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule